// File: doc/BRIEF.md
# Fuse Byte Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse array by generating the array's control pins directly, one edge at a time. A single request carries a starting byte offset and a byte count. The sequencer first opens the array in read mode, then walks the bytes one by one. For each byte it clears and re-applies the address, pulses the strobe, and captures the 8-bit data output while the strobe is still high. The captured byte is offered on a valid/ready stream. When the last byte has been taken, the array is returned to standby.

Every gap around the strobe is counted in clock cycles from one parameter, the number of clocks in a microsecond. The design therefore meets the array's one-microsecond set-up and hold rules at any clock rate. The control pins are gathered into one 16-bit control word. Bit 0 is chip select (active low), bit 1 is strobe, bit 2 is load, bit 3 is program-enable (active low) and bits 15:6 hold the 10-bit byte address. Bits 5:4 are always zero. A consumer that stalls the output stream simply stretches the time the strobe spends low.

Top module: `fuse_byte_reader`

## Requirements
- R1: After reset, and whenever `busy` is low, the control word is the standby value 0x0009: chip select high, program-enable high, load low, strobe low, address zero. `byte_valid` is low after reset.
- R2: On the clock edge that accepts a request with a non-zero count, the control word becomes 0x000C (load high, program-enable high, chip select low, address zero). Read mode is then held for at least CLK_PER_US + 1 + CLK_PER_US cycles before the first strobe rises. Program-enable (bit 3) is never driven low.
- R3: Before each strobe, the address field (bits 15:6) passes through zero and is then driven to the byte's address. That address is held unchanged for at least CLK_PER_US cycles before the strobe rises, and it stays unchanged while the strobe is high.
- R4: The strobe (bit 1) stays high for at least CLK_PER_US cycles and rises only while chip select is low and load is high. The returned byte equals `fuse_dout` as sampled at the strobe's falling edge.
- R5: Between a strobe falling and the next strobe rising at least 2*CLK_PER_US + 1 cycles pass, the first CLK_PER_US of them with the previous address still driven.
- R6: A request for N bytes at offset F strobes the addresses (F + i) mod 1024 for i = 0..N-1, in that order. It returns exactly N bytes in the same order, so address 1023 is followed by address 0.
- R7: After the last byte has been accepted on the stream, the control word returns to 0x0009 and `busy` falls.
- R8: A request with a count of zero raises `busy` for exactly one cycle. It produces no strobe and no output byte, and leaves the control word at 0x0009.
- R9: `req_valid` is ignored while `busy` is high: the running read keeps its addresses and byte count, and no further read follows it.
- R10: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high, `byte_data` stays stable and the strobe stays low. No next strobe occurs until the byte is accepted.
- R11: `busy` is high from the cycle after a request is accepted until the standby word is driven at the end, and it is high whenever the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_offset | input | 10 | Starting byte address |
| req_count | input | CNT_W | Number of bytes to read (zero allowed) |
| busy | output | 1 | A read or its closing standby cycle is in progress |
| fuse_ctrl | output | 16 | Control word to the fuse array (bit layout in R1 to R4) |
| fuse_dout | input | 8 | Data output of the fuse array |
| byte_valid | output | 1 | A captured byte is offered |
| byte_ready | input | 1 | Consumer accepts the offered byte |
| byte_data | output | 8 | Captured byte |

## Verification
The assertions take for granted that the consumer may hold `byte_ready` low for any length of time and that `fuse_dout` is meaningful only while the strobe is high. They assume nothing about when `req_valid` arrives, so requests during a read are legal stimulus. The bench models the fuse array as a fixed function of the address presented on the control word and drives `fuse_dout` from that function only while strobe is high. It stalls the stream only through `byte_ready`, in an always-ready pattern, a one-in-three pattern and a long full stop. It sends requests while busy on purpose, to show they are dropped.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    // Address field width is fixed by the control word layout.
    localparam int FUSE_ADDR_W = 10;
    localparam int FUSE_DATA_W = 8;
    localparam int CTRL_W      = 16;

    typedef logic [FUSE_ADDR_W-1:0] fuse_addr_t;
    typedef logic [FUSE_DATA_W-1:0] fuse_byte_t;

    // Packed so that addr lands on bits 15:6 and cs_n on bit 0.
    typedef struct packed {
        fuse_addr_t addr;
        logic [1:0] spare;
        logic       pgm_n;
        logic       load;
        logic       strobe;
        logic       cs_n;
    } fuse_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_ACLR,
        ST_ASET,
        ST_STRB,
        ST_HOLD,
        ST_DONE
    } seq_state_e;

    localparam fuse_ctrl_t CTRL_STANDBY = '{
        addr: '0, spare: '0, pgm_n: 1'b1, load: 1'b0, strobe: 1'b0, cs_n: 1'b1
    };

    // Control word that belongs to a sequencer state.
    function automatic fuse_ctrl_t ctrl_for(seq_state_e st, fuse_addr_t a);
        fuse_ctrl_t c;
        c = CTRL_STANDBY;
        case (st)
            ST_OPEN, ST_ACLR: begin
                c.cs_n = 1'b0;
                c.load = 1'b1;
            end
            ST_ASET, ST_HOLD: begin
                c.cs_n = 1'b0;
                c.load = 1'b1;
                c.addr = a;
            end
            ST_STRB: begin
                c.cs_n   = 1'b0;
                c.load   = 1'b1;
                c.addr   = a;
                c.strobe = 1'b1;
            end
            default: c = CTRL_STANDBY;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fuse_gap_timer.sv
// Counts cycles spent in the current sequencer state; saturates at GAP-1.
module fuse_gap_timer #(
    parameter int GAP = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic elapsed
);
    localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign elapsed = (cnt_q == LAST);
endmodule

// File: rtl/fuse_addr_track.sv
// Holds the current byte address and the number of bytes still to read.
module fuse_addr_track
    import fuse_rd_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  fuse_addr_t       start_addr,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             step,
    output fuse_addr_t       addr_q,
    output fuse_addr_t       addr_nxt,
    output logic             last
);
    logic [CNT_W-1:0] left_q;

    // Address arithmetic wraps modulo the 10-bit field.
    always_comb begin
        if (load) begin
            addr_nxt = start_addr;
        end else if (step) begin
            addr_nxt = addr_q + 1'b1;
        end else begin
            addr_nxt = addr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            left_q <= '0;
        end else begin
            addr_q <= addr_nxt;
            if (load) begin
                left_q <= start_cnt;
            end else if (step) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign last = (left_q == CNT_W'(1));
endmodule

// File: rtl/fuse_byte_slot.sv
// Single-entry output holding register for the stream side.
module fuse_byte_slot
    import fuse_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  fuse_byte_t din,
    input  logic       ready,
    output logic       valid,
    output fuse_byte_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (capture) begin
            valid <= 1'b1;
            data  <= din;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/fuse_byte_reader.sv
module fuse_byte_reader
    import fuse_rd_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int CNT_W      = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [FUSE_ADDR_W-1:0] req_offset,
    input  logic [CNT_W-1:0]       req_count,
    output logic                   busy,
    output logic [CTRL_W-1:0]      fuse_ctrl,
    input  logic [FUSE_DATA_W-1:0] fuse_dout,
    output logic                   byte_valid,
    input  logic                   byte_ready,
    output logic [FUSE_DATA_W-1:0] byte_data
);
    seq_state_e state_q, state_d;
    fuse_ctrl_t ctrl_q;
    fuse_addr_t addr_q, addr_nxt;
    logic       gap_done, last_byte;
    logic       accept, step, capture, restart;

    // Next-state logic: each timed state lasts CLK_PER_US cycles.
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        step    = 1'b0;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = (req_count == '0) ? ST_DONE : ST_OPEN;
                end
            end
            ST_OPEN: if (gap_done) state_d = ST_ACLR;
            ST_ACLR: state_d = ST_ASET;
            ST_ASET: if (gap_done) state_d = ST_STRB;
            ST_STRB: begin
                if (gap_done) begin
                    capture = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                // Strobe stays low until the gap ends and the slot is empty.
                if (gap_done && !byte_valid) begin
                    step    = 1'b1;
                    state_d = last_byte ? ST_DONE : ST_ACLR;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign restart = (state_d != state_q);

    fuse_gap_timer #(
        .GAP(CLK_PER_US)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .elapsed(gap_done)
    );

    fuse_addr_track #(
        .CNT_W(CNT_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .start_addr(req_offset),
        .start_cnt (req_count),
        .step      (step),
        .addr_q    (addr_q),
        .addr_nxt  (addr_nxt),
        .last      (last_byte)
    );

    fuse_byte_slot u_slot (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .din    (fuse_dout),
        .ready  (byte_ready),
        .valid  (byte_valid),
        .data   (byte_data)
    );

    // Control word registered from the next state so pins change
    // on the same edge as the state and never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= CTRL_STANDBY;
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_for(state_d, addr_nxt);
        end
    end

    assign fuse_ctrl = ctrl_q;
    assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/fuse_byte_reader_chk.sv
module fuse_byte_reader_chk #(
    parameter int CLK_PER_US = 50
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic [15:0] fuse_ctrl,
    input logic        byte_valid,
    input logic        byte_ready,
    input logic [7:0]  byte_data
);
    logic [31:0] hi_cnt;

    // Consecutive cycles the strobe has been high, up to the previous cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (fuse_ctrl[1]) begin
            hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= '0;
        end
    end

    p_idle_standby_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fuse_ctrl == 16'h0009));

    p_no_program_r2: assert property (@(posedge clk) disable iff (rst)
        fuse_ctrl[3] == 1'b1);

    p_addr_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (fuse_ctrl[1] && $past(fuse_ctrl[1])) |-> $stable(fuse_ctrl[15:6]));

    p_strobe_in_read_r4: assert property (@(posedge clk) disable iff (rst)
        fuse_ctrl[1] |-> (!fuse_ctrl[0] && fuse_ctrl[2]));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(fuse_ctrl[1]) |-> (hi_cnt >= 32'(CLK_PER_US)));

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    p_no_strobe_pending_r10: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !fuse_ctrl[1]);

    p_busy_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        fuse_ctrl[1] |-> busy);
endmodule

bind fuse_byte_reader fuse_byte_reader_chk #(
    .CLK_PER_US(CLK_PER_US)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .fuse_ctrl (fuse_ctrl),
    .byte_valid(byte_valid),
    .byte_ready(byte_ready),
    .byte_data (byte_data)
);

// File: tb/tb_fuse_byte_reader.sv
`timescale 1ns/1ps
module tb_fuse_byte_reader;
    localparam int G     = 4;
    localparam int CNT_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [9:0]       req_offset = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic             busy;
    logic [15:0]      fuse_ctrl;
    logic [7:0]       fuse_dout;
    logic             byte_valid;
    logic             byte_ready = 1'b0;
    logic [7:0]       byte_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int rdy_mode = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    fuse_byte_reader #(.CLK_PER_US(G), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_offset(req_offset),
        .req_count(req_count), .busy(busy), .fuse_ctrl(fuse_ctrl),
        .fuse_dout(fuse_dout), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .byte_data(byte_data)
    );

    function automatic logic [7:0] fuse_model(logic [9:0] a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // Fuse array model: data visible only while strobe is high.
    assign fuse_dout = fuse_ctrl[1] ? fuse_model(fuse_ctrl[15:6]) : 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Consumer ready pattern.
    always @(posedge clk) begin
        #1;
        cyc++;
        case (rdy_mode)
            0: byte_ready = 1'b1;
            1: byte_ready = (cyc % 3 == 0);
            default: byte_ready = 1'b0;
        endcase
    end

    // Pin monitor and stream collector.
    logic [15:0] pc;
    int addr_age, hi_cnt, lo_cnt, cs_age;
    bit first_pend, clr_seen;
    logic [9:0] rise_addr [64];
    logic [7:0] got_data [64];
    int rise_n, got_n;

    always @(negedge clk) begin
        if (rst) begin
            pc = 16'h0009; addr_age = 0; hi_cnt = 0; lo_cnt = 0; cs_age = 0;
            first_pend = 0; clr_seen = 0;
        end else begin
            if (fuse_ctrl[1] && !pc[1]) begin
                if (rise_n < 64) rise_addr[rise_n] = fuse_ctrl[15:6];
                rise_n++;
                chk(addr_age >= G, "R3 address set-up", addr_age, G);
                chk(clr_seen, "R3 address cleared", int'(clr_seen), 1);
                if (first_pend) chk(cs_age >= 2*G+1, "R2 open time", cs_age, 2*G+1);
                else chk(lo_cnt >= 2*G+1, "R5 strobe low gap", lo_cnt, 2*G+1);
                first_pend = 0;
                clr_seen = 0;
            end
            if (!fuse_ctrl[1] && pc[1]) chk(hi_cnt >= G, "R4 strobe width", hi_cnt, G);
            if (!fuse_ctrl[0] && pc[0]) first_pend = 1;
            if (!fuse_ctrl[0] && !fuse_ctrl[1] && fuse_ctrl[15:6] == 10'd0) clr_seen = 1;
            addr_age = (fuse_ctrl[15:6] == pc[15:6]) ? addr_age + 1 : 1;
            hi_cnt = fuse_ctrl[1] ? hi_cnt + 1 : 0;
            lo_cnt = fuse_ctrl[1] ? 0 : lo_cnt + 1;
            cs_age = fuse_ctrl[0] ? 0 : cs_age + 1;
            if (byte_valid && byte_ready) begin
                if (got_n < 64) got_data[got_n] = byte_data;
                got_n++;
            end
            pc = fuse_ctrl;
        end
    end

    task automatic clear_logs();
        rise_n = 0;
        got_n = 0;
    endtask

    task automatic issue(input logic [9:0] ofs, input int n);
        @(posedge clk); #1;
        req_offset = ofs;
        req_count = CNT_W'(n);
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic check_result(input string tag, input logic [9:0] ofs, input int n);
        chk(got_n == n, {tag, " R6 byte count"}, got_n, n);
        chk(rise_n == n, {tag, " R6 strobe count"}, rise_n, n);
        for (int i = 0; i < n && i < got_n && i < rise_n; i++) begin
            logic [9:0] ea;
            ea = ofs + 10'(i);
            chk(rise_addr[i] == ea, {tag, " R6 address order"}, int'(rise_addr[i]), int'(ea));
            chk(got_data[i] == fuse_model(ea), {tag, " R4 data"}, int'(got_data[i]), int'(fuse_model(ea)));
        end
        chk(fuse_ctrl == 16'h0009, {tag, " R7 standby word"}, int'(fuse_ctrl), 16'h0009);
        chk(!busy, {tag, " R7 busy low"}, int'(busy), 0);
        chk(!byte_valid, {tag, " R7 no byte left"}, int'(byte_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(fuse_ctrl == 16'h0009, "R1 reset word", int'(fuse_ctrl), 16'h0009);
        chk(!busy, "R1 reset busy", int'(busy), 0);
        chk(!byte_valid, "R1 reset valid", int'(byte_valid), 0);
    endtask

    task automatic t_single();
        clear_logs();
        rdy_mode = 0;
        issue(10'd37, 1);
        @(negedge clk);
        chk(fuse_ctrl == 16'h000C, "R2 read-mode word", int'(fuse_ctrl), 16'h000C);
        chk(busy, "R11 busy after accept", int'(busy), 1);
        wait_idle();
        check_result("single", 10'd37, 1);
    endtask

    task automatic t_multi_slow();
        clear_logs();
        rdy_mode = 1;
        issue(10'd200, 6);
        wait_idle();
        check_result("multi", 10'd200, 6);
        rdy_mode = 0;
    endtask

    task automatic t_wrap();
        clear_logs();
        rdy_mode = 0;
        issue(10'd1022, 4);
        wait_idle();
        check_result("wrap", 10'd1022, 4);
    endtask

    task automatic t_zero();
        clear_logs();
        issue(10'd5, 0);
        @(negedge clk);
        chk(busy, "R8 busy pulse", int'(busy), 1);
        chk(fuse_ctrl == 16'h0009, "R8 word stays standby", int'(fuse_ctrl), 16'h0009);
        @(negedge clk);
        chk(!busy, "R8 busy one cycle", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(got_n == 0, "R8 no bytes", got_n, 0);
        chk(rise_n == 0, "R8 no strobe", rise_n, 0);
    endtask

    task automatic t_ignore_busy();
        clear_logs();
        rdy_mode = 0;
        issue(10'd100, 3);
        repeat (10) @(posedge clk);
        #1;
        req_offset = 10'd500;
        req_count = CNT_W'(9);
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();
        check_result("ignore R9", 10'd100, 3);
        repeat (8) @(negedge clk);
        chk(!busy, "R9 no follow-on read", int'(busy), 0);
        chk(rise_n == 3, "R9 strobe count unchanged", rise_n, 3);
    endtask

    task automatic t_backpressure();
        logic [7:0] held;
        int rn;
        clear_logs();
        rdy_mode = 2;
        issue(10'd640, 2);
        for (int i = 0; i < 2000 && !byte_valid; i++) @(negedge clk);
        chk(byte_valid, "R10 byte offered", int'(byte_valid), 1);
        held = byte_data;
        rn = rise_n;
        for (int i = 0; i < 6*G; i++) begin
            @(negedge clk);
            if (!byte_valid || byte_data != held || fuse_ctrl[1]) begin
                chk(0, "R10 stall hold", int'(byte_data), int'(held));
                break;
            end
        end
        chk(rise_n == rn, "R10 no strobe while pending", rise_n, rn);
        chk(busy, "R11 busy during stall", int'(busy), 1);
        rdy_mode = 0;
        wait_idle();
        check_result("stall R10", 10'd640, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_logs();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_single();
        t_multi_slow();
        t_wrap();
        t_zero();
        t_ignore_busy();
        t_backpressure();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule